// File: doc/BRIEF.md
# Wired-AND Serial Bus Address-Phase Arbiter

This block runs the address phase of a frame on a single-wire serial bus where any unit pulling the line low wins over a unit releasing it. Bit timing is abstracted into two strobes. A slot strobe opens each bit slot, and the block updates its drive level then. A mid-slot sample strobe marks when the bus level is valid, and the block evaluates that level then.

A start request loads the unit's own address, the destination address and a broadcast flag. The block sends its own 12-bit address most significant bit first. In each slot it compares the bit it sent with the level it reads back. On the first mismatch it releases the line. It then records the rest of the winning address as a receiver and reports lost arbitration. A unit that survives all 12 bits sends an even parity bit. It then sends the 12-bit destination address and its parity bit, and releases the line for an acknowledge slot. The block ends with a one-cycle done pulse and a 2-bit result code.

The observed master address field is available on a capture output after every frame. A receive path can use it to learn who won.

Top module: `wab_addr_phase`

## Requirements
- R1: While reset is asserted, and whenever no frame is in progress, drive_o is 1 (line released), busy_o is 0 and done_o is 0.
- R2: A start_i pulse while idle begins a frame and raises busy_o. A start_i while busy_o is 1 is ignored and does not change the frame in progress.
- R3: The own address is driven bit 11 first, down to bit 0, one bit per slot. drive_o takes the bit value one clock after slot_i and changes at no other time except as stated in R4.
- R4: If the bus level read at a sample strobe differs from the bit being driven in a master address slot, arbitration is lost. drive_o returns to 1 one clock later and stays 1 until the frame ends.
- R5: After a loss the block keeps sampling to the end of the 12-bit field. It then ends with result 1 (lost). capt_o holds the 12 sampled levels, the first at bit 11.
- R6: A winning unit drives a 13th slot carrying even parity of its own address: 1 when that address has an odd count of ones.
- R7: The destination address then follows bit 11 first, in 12 slots, then a slot carrying its even parity bit.
- R8: In the acknowledge slot drive_o is 1. For a normal frame, a sampled 0 ends with result 0 (ok) and a sampled 1 ends with result 2 (no acknowledge).
- R9: For a broadcast frame the acknowledge level is not checked, and the frame ends with result 3 (broadcast done).
- R10: done_o is a one-clock pulse. It appears one clock after the final sample strobe, in the same cycle that busy_o falls. result_o changes only together with done_o.
- R11: A sample strobe that is not preceded by a slot strobe in the current slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (honoured only when idle) |
| own_addr_i | input | 12 | Own (master) address |
| dest_addr_i | input | 12 | Destination (slave) address |
| bcast_i | input | 1 | Frame is a broadcast |
| slot_i | input | 1 | Bit-slot start strobe |
| samp_i | input | 1 | Mid-slot sample strobe |
| bus_i | input | 1 | Sampled bus level |
| drive_o | output | 1 | Line drive level (1 = released) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-phase pulse |
| result_o | output | 2 | 0 ok, 1 lost, 2 no ack, 3 broadcast |
| capt_o | output | 12 | Observed master address field |

## Verification
A corrupted bit index or state shows up as a wrong drive_o level in the very next slot. This appears well before the done pulse, so every slot's drive level is compared against a bench model of the whole frame. A wrong loss decision or a wrong capture register shows up only at the done pulse, where the result code and capt_o are compared with a wired-AND model of two competing units. Stray strobes and restarts are injected mid-frame. Their effect, if any, would appear as a changed drive level at the next slot or a changed result at the end.

// File: rtl/wab_pkg.sv
package wab_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MADDR = 3'd1,
    ST_MPAR  = 3'd2,
    ST_SADDR = 3'd3,
    ST_SPAR  = 3'd4,
    ST_ACK   = 3'd5,
    ST_RECV  = 3'd6
  } wab_state_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_LOST  = 2'd1,
    RES_NACK  = 2'd2,
    RES_BCAST = 2'd3
  } wab_result_e;
endpackage

// File: rtl/wab_rst_sync.sv
module wab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= 1'b0;
        else          chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= '0;
        else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/wab_bit_idx.sv
module wab_bit_idx #(
  parameter int WIDTH = 12,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          dec_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [IW-1:0] TOP = IW'(WIDTH - 1);
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_i)     idx_d = TOP;
    else if (dec_i) idx_d = idx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= TOP;
    else        idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == '0);
endmodule

// File: rtl/wab_capture.sv
module wab_capture #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (clr_i)        data_d = '0;
    else if (shift_i) data_d = {data_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/wab_addr_phase.sv
module wab_addr_phase
  import wab_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic              bcast_i,
  input  logic              slot_i,
  input  logic              samp_i,
  input  logic              bus_i,
  output logic              drive_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [ADDR_W-1:0] capt_o
);
  localparam int IW = $clog2(ADDR_W);

  logic rst_sn;
  wab_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sn)
  );

  wab_state_e        state_q, state_d;
  logic              armed_q, armed_d;
  logic              drive_q, drive_d;
  logic              bcast_q, bcast_d;
  logic              done_q, done_d;
  logic [1:0]        result_q, result_d;
  logic [ADDR_W-1:0] own_q, own_d, dest_q, dest_d;

  logic          idx_load, idx_dec, idx_last;
  logic [IW-1:0] idx;
  logic          cap_clr, cap_shift;

  wab_bit_idx #(.WIDTH(ADDR_W)) u_idx (
    .clk(clk), .rst_n(rst_sn), .load_i(idx_load), .dec_i(idx_dec),
    .idx_o(idx), .last_o(idx_last)
  );

  wab_capture #(.WIDTH(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_sn), .clr_i(cap_clr), .shift_i(cap_shift),
    .bit_i(bus_i), .data_o(capt_o)
  );

  logic slot_ev, samp_ev;
  assign slot_ev = slot_i && (state_q != ST_IDLE);
  assign samp_ev = samp_i && !slot_i && armed_q && (state_q != ST_IDLE);

  // next-state process
  always_comb begin
    state_d   = state_q;
    armed_d   = armed_q;
    drive_d   = drive_q;
    bcast_d   = bcast_q;
    own_d     = own_q;
    dest_d    = dest_q;
    result_d  = result_q;
    done_d    = 1'b0;
    idx_load  = 1'b0;
    idx_dec   = 1'b0;
    cap_clr   = 1'b0;
    cap_shift = 1'b0;

    if (state_q == ST_IDLE) begin
      drive_d = 1'b1;
      armed_d = 1'b0;
      if (start_i) begin
        own_d    = own_addr_i;
        dest_d   = dest_addr_i;
        bcast_d  = bcast_i;
        state_d  = ST_MADDR;
        idx_load = 1'b1;
        cap_clr  = 1'b1;
      end
    end else if (slot_ev) begin
      armed_d = 1'b1;
      case (state_q)
        ST_MADDR: drive_d = own_q[idx];
        ST_MPAR:  drive_d = ^own_q;
        ST_SADDR: drive_d = dest_q[idx];
        ST_SPAR:  drive_d = ^dest_q;
        default:  drive_d = 1'b1;
      endcase
    end else if (samp_ev) begin
      armed_d = 1'b0;
      case (state_q)
        ST_MADDR: begin
          cap_shift = 1'b1;
          idx_dec   = !idx_last;
          if (bus_i != drive_q) begin
            drive_d = 1'b1;
            state_d = ST_RECV;
          end else if (idx_last) begin
            state_d = ST_MPAR;
          end
          if ((bus_i != drive_q) && idx_last) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = RES_LOST;
          end
        end
        ST_RECV: begin
          cap_shift = 1'b1;
          idx_dec   = !idx_last;
          if (idx_last) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = RES_LOST;
          end
        end
        ST_MPAR: begin
          state_d  = ST_SADDR;
          idx_load = 1'b1;
        end
        ST_SADDR: begin
          idx_dec = !idx_last;
          if (idx_last) state_d = ST_SPAR;
        end
        ST_SPAR: state_d = ST_ACK;
        ST_ACK: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          drive_d = 1'b1;
          if (bcast_q)    result_d = RES_BCAST;
          else if (bus_i) result_d = RES_NACK;
          else            result_d = RES_OK;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_IDLE;
      armed_q  <= 1'b0;
      drive_q  <= 1'b1;
      bcast_q  <= 1'b0;
      done_q   <= 1'b0;
      result_q <= RES_OK;
      own_q    <= '0;
      dest_q   <= '0;
    end else begin
      state_q  <= state_d;
      armed_q  <= armed_d;
      drive_q  <= drive_d;
      bcast_q  <= bcast_d;
      done_q   <= done_d;
      result_q <= result_d;
      own_q    <= own_d;
      dest_q   <= dest_d;
    end
  end

  assign drive_o  = drive_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/wab_addr_phase_chk.sv
module wab_addr_phase_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              slot_i,
  input logic              samp_i,
  input logic              drive_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o,
  input logic [ADDR_W-1:0] capt_o
);
  // R1: an idle unit never pulls the line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> drive_o);

  // R3: the drive level moves only after a strobe
  a_r3_drive_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_i && !samp_i) |=> $stable(drive_o));

  // R2: a restart request cannot end a running frame
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !samp_i) |=> busy_o);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: done comes as busy falls
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R10: result only moves with done
  a_r10_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  // R5: capture register frozen while idle and no start
  a_r5_capt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(capt_o));
endmodule

bind wab_addr_phase wab_addr_phase_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .slot_i(slot_i),
  .samp_i(samp_i), .drive_o(drive_o), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o), .capt_o(capt_o)
);

// File: tb/wab_addr_phase_test.sv
module wab_addr_phase_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, bcast_i, slot_i, samp_i;
  logic [11:0] own_addr_i, dest_addr_i;
  logic        ext_line;
  logic        bus_i;
  logic        drive_o, busy_o, done_o;
  logic [1:0]  result_o;
  logic [11:0] capt_o;

  int vectors = 0;
  int errors  = 0;
  logic [13:0] expq[$];

  always #5 clk = ~clk;

  assign bus_i = drive_o & ext_line;

  wab_addr_phase uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .own_addr_i(own_addr_i),
    .dest_addr_i(dest_addr_i), .bcast_i(bcast_i), .slot_i(slot_i),
    .samp_i(samp_i), .bus_i(bus_i), .drive_o(drive_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .capt_o(capt_o)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops expected {result,capture} at each done pulse (R5 R8 R9 R10)
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) begin
        check("R10", "unexpected done", 1, 0);
      end else begin
        logic [13:0] e;
        e = expq.pop_front();
        check(e[13:12] == 2'd1 ? "R5" : (e[13:12] == 2'd3 ? "R9" : "R8"),
              "result", result_o, e[13:12]);
        check("R5", "capture", capt_o, e[11:0]);
        check("R10", "busy at done", busy_o, 0);
      end
    end
  end

  task automatic pulse_slot();
    @(negedge clk) slot_i = 1'b1;
    @(negedge clk) slot_i = 1'b0;
  endtask

  task automatic pulse_samp();
    @(negedge clk) samp_i = 1'b1;
    @(negedge clk) samp_i = 1'b0;
  endtask

  task automatic run_frame(input logic [11:0] own, input logic [11:0] dest,
                           input bit bc, input bit rival_on, input logic [11:0] rival,
                           input bit ack_lvl, input bit poke_start, input bit stray);
    logic exp_drv[27];
    logic ext_v[27];
    logic [11:0] cap;
    bit own_alive, riv_alive, lost;
    int nslots;
    logic [1:0] res;
    own_alive = 1; riv_alive = rival_on; lost = 0; cap = '0;
    for (int s = 0; s < 12; s++) begin
      logic ob, rb, bl;
      ob = own_alive ? own[11-s] : 1'b1;
      rb = riv_alive ? rival[11-s] : 1'b1;
      bl = ob & rb;
      exp_drv[s] = ob; ext_v[s] = rb;
      cap = {cap[10:0], bl};
      if (own_alive && ob != bl) begin own_alive = 0; lost = 1; end
      if (riv_alive && rb != bl) riv_alive = 0;
    end
    exp_drv[12] = ^own; ext_v[12] = 1'b1;
    for (int s = 13; s < 25; s++) begin exp_drv[s] = dest[24-s]; ext_v[s] = 1'b1; end
    exp_drv[25] = ^dest; ext_v[25] = 1'b1;
    exp_drv[26] = 1'b1;  ext_v[26] = ack_lvl;
    nslots = lost ? 12 : 27;
    res = lost ? 2'd1 : (bc ? 2'd3 : (ack_lvl ? 2'd2 : 2'd0));
    expq.push_back({res, cap});

    @(negedge clk);
    own_addr_i = own; dest_addr_i = dest; bcast_i = bc; start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check("R2", "busy after start", busy_o, 1);
    check("R1", "released before first slot", drive_o, 1);

    for (int s = 0; s < nslots; s++) begin
      string rq;
      rq = (s < 12) ? ((lost && exp_drv[s] == 1'b1 && s > 0 && exp_drv[s-1] == 1'b1 && !own[12-s]) ? "R4" : "R3")
         : (s == 12) ? "R6" : (s < 26) ? "R7" : "R8";
      pulse_slot();
      check(rq, $sformatf("drive slot %0d", s), drive_o, exp_drv[s]);
      ext_line = ext_v[s];
      pulse_samp();
      ext_line = 1'b1;
      if (stray && s == 0) begin
        ext_line = 1'b0;   // R11: would force a mismatch if honoured
        pulse_samp();
        ext_line = 1'b1;
        check("R11", "drive after stray sample", drive_o, exp_drv[0]);
      end
      if (poke_start && s == 5) begin
        own_addr_i = 12'h000; dest_addr_i = 12'hFFF; bcast_i = ~bc;
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check("R2", "busy after ignored start", busy_o, 1);
      end
    end
    repeat (2) @(negedge clk);
    check("R1", "idle drive", drive_o, 1);
    check("R1", "idle busy", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 0; bcast_i = 0; slot_i = 0; samp_i = 0;
    own_addr_i = '0; dest_addr_i = '0; ext_line = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset drive", drive_o, 1);
    check("R1", "reset busy", busy_o, 0);
    check("R1", "reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_frame(12'hA5C, 12'h3F1, 0, 0, 12'h000, 0, 0, 0); // R8 ok
    run_frame(12'h007, 12'h800, 0, 0, 12'h000, 1, 0, 0); // R8 nack, R6 odd parity
    run_frame(12'hFFF, 12'h000, 1, 0, 12'h000, 1, 0, 0); // R9 ack high
    run_frame(12'h000, 12'hFFF, 1, 0, 12'h000, 0, 0, 0); // R9 ack low
    run_frame(12'h800, 12'h123, 0, 1, 12'h7FF, 0, 0, 0); // R4 lost at first bit
    run_frame(12'h123, 12'h456, 0, 1, 12'h124, 0, 0, 0); // win over larger rival
    run_frame(12'h001, 12'h456, 0, 1, 12'h000, 0, 0, 0); // R5 lost at last bit
    run_frame(12'h6B3, 12'h2C8, 0, 1, 12'h6A9, 0, 0, 0); // R5 lost mid-field
    run_frame(12'hC00, 12'h0F0, 0, 0, 12'h000, 0, 1, 1); // R2 R11

    repeat (4) @(negedge clk);
    check("R10", "pending results", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule